// File: doc/BRIEF.md
# Iterative 1024-bit P/Q Permutation Engine

This block runs a 14-round wide permutation over a 128-byte state, one round per clock. A single control bit picks one of two variants, P or Q. The variants share all of the datapath and differ only in their round constants and in how far each row is rotated. Every round applies four steps in a fixed order: a constant addition, a byte substitution through the AES S-box, a rotation of each row, and a column mix over GF(2^8).

A caller presents a 1024-bit state and the mode bit, then pulses `start` while the engine is idle. The engine captures the state and raises `busy` for the length of the run. When the last round has been applied it lowers `busy`, pulses `done` for one cycle and leaves the permuted state on `dout`. Chaining of several permutations and message padding belong to the surrounding logic.

Top module: `grp_perm_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy` and `done` are 0 and `dout` is all zeros.
- R2: Byte k of a state (k = 0..127) occupies bits [1023-8k -: 8]. It sits at row k mod 8 and column k div 8 of an 8-row by 16-column matrix. The same layout applies to `din` and to `dout`.
- R3: A `start` sampled while idle captures `din` and the mode, and `busy` is 1 in the following cycle. Rounds 0 to 13 are applied on the next 14 clock edges, one per edge. `done` is 1 in the cycle just after the edge that applies round 13, which is 14 cycles after the cycle in which `busy` first reads 1.
- R4: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1. A `start` given in the same cycle as `done` begins a new run.
- R5: While `busy` is 1, the inputs `start`, `din` and `mode_q` have no effect: the run ends at its normal time with the result for the data captured at its start.
- R6: In P mode (`mode_q` = 0), the constant XORed into row 0, column j in round r is (16*j) XOR r, where r is zero-extended to 8 bits. Every other row is XORed with 0x00.
- R7: In Q mode (`mode_q` = 1), the constant for row 7, column j in round r is 0xFF XOR (16*j) XOR r. Every other row is XORed with 0xFF.
- R8: Each byte is replaced by its AES S-box value: the multiplicative inverse modulo 0x11B (0 maps to 0), followed by the AES affine map with the constant 0x63. For example, 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R9: Row i is rotated left by s(i) columns, so that new[i][j] = old[i][(j + s(i)) mod 16]. In P mode s = 0,1,2,3,4,5,6,11 for rows 0..7. In Q mode s = 1,3,5,11,0,2,4,6.
- R10: The column mix computes new[i][j] as the XOR over k of c((k - i) mod 8) times old[k][j] in GF(2^8) modulo 0x11B, with c = 02,02,03,04,05,03,05,07.
- R11: `dout` changes only on the edge that sets `done`. It keeps the previous result throughout a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a permutation when idle |
| mode_q | input | 1 | 0 selects P, 1 selects Q |
| din | input | 1024 | State to permute |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| dout | output | 1024 | Registered permuted state |

## Verification
The assertions assume that reset is applied before the first run and that `start` is only acted on from the idle state. They place no constraint on `din` or on when `start` is raised. The stimulus changes inputs only on the falling clock edge and holds `start` for single cycles. It deliberately raises `start` with different data and the opposite mode in the middle of a run, so that the hold and run-length properties are exercised against inputs that must be ignored. A second instance built for a single round exposes each round step directly, while the 14-round instance checks how the rounds chain together.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int BYTE_W  = 8;
  localparam int ROWS    = 8;
  localparam int COLS    = 16;
  localparam int STATE_W = BYTE_W * ROWS * COLS;
  localparam logic [7:0] GF_REDUCE = 8'h1b;

  typedef enum logic {PERM_P = 1'b0, PERM_Q = 1'b1} perm_mode_e;

  // lsb of the byte at (row, col); column-major fill, byte 0 at the top
  function automatic int byte_lsb(input int r, input int c);
    return STATE_W - BYTE_W * (c * ROWS + r + 1);
  endfunction

  function automatic int shift_amt(input bit q, input int r);
    int s;
    if (q) begin
      case (r)
        0: s = 1;  1: s = 3;  2: s = 5;  3: s = 11;
        4: s = 0;  5: s = 2;  6: s = 4;  default: s = 6;
      endcase
    end else begin
      s = (r == ROWS - 1) ? 11 : r;
    end
    return s;
  endfunction

  function automatic logic [7:0] mix_coef(input int d);
    logic [7:0] v;
    case (d)
      0, 1:    v = 8'h02;
      2, 5:    v = 8'h03;
      3:       v = 8'h04;
      4, 6:    v = 8'h05;
      default: v = 8'h07;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? GF_REDUCE : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // x^254 by repeated squaring; zero stays zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = x;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_eval(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/grp_add_const.sv
module grp_add_const
  import grp_pkg::*;
(
  input  perm_mode_e         mode,
  input  logic [7:0]         rnd,
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] dout
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int         LSB  = byte_lsb(r, c);
      localparam logic [7:0] COLK = 8'(c * 16);
      logic [7:0] kb;
      always_comb begin
        if (mode == PERM_Q) kb = (r == ROWS - 1) ? (8'hFF ^ COLK ^ rnd) : 8'hFF;
        else                kb = (r == 0)        ? (COLK ^ rnd)         : 8'h00;
      end
      assign dout[LSB +: BYTE_W] = din[LSB +: BYTE_W] ^ kb;
    end
  end
endmodule

// File: rtl/grp_sub_bytes.sv
module grp_sub_bytes
  import grp_pkg::*;
(
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] dout
);
  localparam int NBYTES = STATE_W / BYTE_W;
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[i*BYTE_W +: BYTE_W] = sbox_eval(din[i*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/grp_shift_bytes.sv
module grp_shift_bytes
  import grp_pkg::*;
(
  input  perm_mode_e         mode,
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] dout
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int DST   = byte_lsb(r, c);
      localparam int SRC_P = byte_lsb(r, (c + shift_amt(1'b0, r)) % COLS);
      localparam int SRC_Q = byte_lsb(r, (c + shift_amt(1'b1, r)) % COLS);
      assign dout[DST +: BYTE_W] = (mode == PERM_Q) ? din[SRC_Q +: BYTE_W]
                                                    : din[SRC_P +: BYTE_W];
    end
  end
endmodule

// File: rtl/grp_mix_bytes.sv
module grp_mix_bytes
  import grp_pkg::*;
(
  input  logic [STATE_W-1:0] din,
  output logic [STATE_W-1:0] dout
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [7:0] acc;
      always_comb begin
        acc = '0;
        for (int k = 0; k < ROWS; k++) begin
          acc = acc ^ gf_mul(din[byte_lsb(k, c) +: BYTE_W],
                             mix_coef((k - r + ROWS) % ROWS));
        end
      end
      assign dout[byte_lsb(r, c) +: BYTE_W] = acc;
    end
  end
endmodule

// File: rtl/grp_perm_core.sv
module grp_perm_core
  import grp_pkg::*;
#(
  parameter int ROUNDS = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               mode_q,
  input  logic [STATE_W-1:0] din,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] dout
);
  localparam int RCW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  perm_mode_e         mode_r;
  logic [RCW-1:0]     rnd;
  logic [STATE_W-1:0] st;
  logic [STATE_W-1:0] s_arc;
  logic [STATE_W-1:0] s_sub;
  logic [STATE_W-1:0] s_shf;
  logic [STATE_W-1:0] s_mix;
  logic               last_rnd;

  assign last_rnd = (rnd == RCW'(ROUNDS - 1));

  grp_add_const u_arc (
    .mode (mode_r),
    .rnd  (8'(rnd)),
    .din  (st),
    .dout (s_arc)
  );

  grp_sub_bytes u_sub (
    .din  (s_arc),
    .dout (s_sub)
  );

  grp_shift_bytes u_shf (
    .mode (mode_r),
    .din  (s_sub),
    .dout (s_shf)
  );

  grp_mix_bytes u_mix (
    .din  (s_shf),
    .dout (s_mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      dout   <= '0;
      st     <= '0;
      rnd    <= '0;
      mode_r <= PERM_P;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st     <= din;
          mode_r <= perm_mode_e'(mode_q);
          rnd    <= '0;
          busy   <= 1'b1;
        end
      end else begin
        st  <= s_mix;
        rnd <= rnd + RCW'(1);
        if (last_rnd) begin
          busy <= 1'b0;
          done <= 1'b1;
          dout <= s_mix;
          rnd  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/grp_perm_chk.sv
module grp_perm_chk #(
  parameter int ROUNDS = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1023:0] dout
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else           run_len <= '0;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_run_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 32'(ROUNDS)));

  p_fell_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_dout_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));
endmodule

bind grp_perm_core grp_perm_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .dout  (dout)
);

// File: tb/grp_perm_core_tb.sv
`timescale 1ns/1ps
module grp_perm_core_tb;
  localparam int NR = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode_q = 1'b0;
  logic [1023:0] din = '0;
  logic          busy, done, busy1, done1;
  logic [1023:0] dout, dout1;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] sb [256];

  always #2.5 clk = ~clk;

  grp_perm_core #(.ROUNDS(NR)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_q(mode_q), .din(din),
    .busy(busy), .done(done), .dout(dout));

  grp_perm_core #(.ROUNDS(1)) u_dut_one (
    .clk(clk), .rst(rst), .start(start), .mode_q(mode_q), .din(din),
    .busy(busy1), .done(done1), .dout(dout1));

  // ---------------- reference model ----------------
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x;
    logic [7:0] y, r;
    x = {1'b0, a}; y = b; r = 8'h00;
    while (y != 0) begin
      if (y[0]) r = r ^ x[7:0];
      x = x << 1;
      if (x[8]) x = x ^ 9'h11b;
      y = y >> 1;
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv, o;
      inv = 8'h00;
      for (int w = 1; w < 256; w++)
        if (gmul(8'(v), 8'(w)) == 8'h01) inv = 8'(w);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
               ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      sb[v] = o;
    end
  endtask

  function automatic logic [1023:0] ref_perm(input logic [1023:0] x, input bit q, input int nr);
    logic [7:0] m [8][16];
    logic [7:0] t [8][16];
    int shp [8] = '{0, 1, 2, 3, 4, 5, 6, 11};
    int shq [8] = '{1, 3, 5, 11, 0, 2, 4, 6};
    logic [7:0] cf [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};
    logic [1023:0] y;
    for (int k = 0; k < 128; k++) m[k%8][k/8] = x[1023-8*k -: 8];
    for (int rd = 0; rd < nr; rd++) begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 16; c++) begin
          logic [7:0] cst;
          if (!q) cst = (r == 0) ? (8'(c*16) ^ 8'(rd)) : 8'h00;
          else    cst = (r == 7) ? ~(8'(c*16) ^ 8'(rd)) : 8'hFF;
          m[r][c] = sb[m[r][c] ^ cst];
        end
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 16; c++)
          t[r][c] = m[r][(c + (q ? shq[r] : shp[r])) % 16];
      for (int c = 0; c < 16; c++)
        for (int r = 0; r < 8; r++) begin
          m[r][c] = 8'h00;
          for (int k = 0; k < 8; k++) m[r][c] = m[r][c] ^ gmul(cf[(k - r + 8) % 8], t[k][c]);
        end
    end
    for (int k = 0; k < 128; k++) y[1023-8*k -: 8] = m[k%8][k/8];
    return y;
  endfunction

  function automatic logic [1023:0] pattern(input int seed);
    logic [1023:0] v;
    for (int k = 0; k < 128; k++) v[1023-8*k -: 8] = 8'(k * 37 + seed) ^ 8'(k >> 3);
    return v;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk_vec(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the start edge
  task automatic launch(input logic [1023:0] d, input bit q);
    start = 1'b1; din = d; mode_q = q;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(inout int cyc);
    while (done !== 1'b1 && cyc < NR + 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk_int("R1 busy after reset", int'(busy), 0);
    chk_int("R1 done after reset", int'(done), 0);
    chk_vec("R1 dout after reset", dout, '0);
  endtask

  task automatic t_model_sanity();
    chk_int("R8 sbox(00)", int'(sb[8'h00]), 'h63);
    chk_int("R8 sbox(53)", int'(sb[8'h53]), 'hED);
  endtask

  task automatic t_run(input string req, input logic [1023:0] d, input bit q);
    int cyc = 0;
    launch(d, q);
    chk_int({req, " R3 busy after start"}, int'(busy), 1);
    wait_done(cyc);
    chk_int({req, " R3 latency"}, cyc, NR);
    chk_int({req, " R4 busy low at done"}, int'(busy), 0);
    chk_vec({req, " one round"}, dout1, ref_perm(d, q, 1));
    chk_vec({req, " full run"}, dout, ref_perm(d, q, NR));
    @(negedge clk);
    chk_int({req, " R4 done pulse width"}, int'(done), 0);
    chk_vec({req, " R11 dout after done"}, dout, ref_perm(d, q, NR));
  endtask

  task automatic t_ignore_busy();
    logic [1023:0] a = pattern(5);
    int cyc = 0;
    launch(a, 1'b0);
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    start = 1'b1; din = pattern(99); mode_q = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    wait_done(cyc);
    chk_int("R5 latency with mid-run start", cyc, NR);
    chk_vec("R5 result unaffected", dout, ref_perm(a, 1'b0, NR));
    @(negedge clk);
    chk_int("R5 no restart", int'(busy), 0);
  endtask

  task automatic t_hold();
    logic [1023:0] prev = dout;
    logic [1023:0] b = pattern(200);
    int cyc = 0;
    int bad = 0;
    launch(b, 1'b1);
    while (done !== 1'b1 && cyc < NR + 20) begin
      if (dout !== prev) bad++;
      @(negedge clk);
      cyc++;
    end
    chk_int("R11 dout held during run", bad, 0);
    chk_vec("R11 new result", dout, ref_perm(b, 1'b1, NR));
  endtask

  task automatic t_chain();
    logic [1023:0] a = pattern(17);
    logic [1023:0] b = pattern(131);
    int cyc = 0;
    launch(a, 1'b1);
    wait_done(cyc);
    chk_vec("R4 first of chain", dout, ref_perm(a, 1'b1, NR));
    launch(b, 1'b0);
    chk_int("R4 start in done cycle accepted", int'(busy), 1);
    cyc = 0;
    wait_done(cyc);
    chk_int("R4 chained latency", cyc, NR);
    chk_vec("R4 chained result", dout, ref_perm(b, 1'b0, NR));
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R3: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_model_sanity();
    t_run("R6 R8 R9 R10 zero state P", '0, 1'b0);
    t_run("R7 R8 R9 R10 zero state Q", '0, 1'b1);
    t_run("R2 R6 pattern P", pattern(1), 1'b0);
    t_run("R2 R7 pattern Q", pattern(1), 1'b1);
    t_run("R2 R9 all ones P", {1024{1'b1}}, 1'b0);
    t_ignore_busy();
    t_hold();
    t_chain();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule